// File: doc/BRIEF.md
# First-level section translation walker

This block resolves a translation-cache miss for a 32-bit virtual address by fetching one first-level descriptor from memory. A split control value N decides which of two table base registers serves the address. When N is zero the low table always serves it. For nonzero N, the low table serves an address only if its top N bits are all zero, and the high table serves every other address. N also shrinks the low table, so the width of the index that the VA contributes to the descriptor address changes with N. The high table always has the full 4096-entry size.

The block presents a single word read on a simple valid/ready request port and takes the reply on a response-valid strobe. It then classifies the word. A section or supersection mapping becomes a one-cycle fill record for the translation cache, carrying the 1 MB virtual page number, the physical page number and the access attributes. An unmapped descriptor raises a fault, and so does a walk disabled for the chosen table, which performs no read at all. A pointer to a second-level table raises a separate fault, because the second level is not walked here. Each fault carries a status code and the faulting VA. A new miss is accepted only while the walker is idle.

Top module: `l1_section_walker`

## Requirements
- R1: Table choice: with split_n = 0 the low base (ttb0) is used; with split_n > 0 the low base is used only when VA[31:32-split_n] are all zero, otherwise the high base (ttb1) is used.
- R2: With the low base, the read address is ttb0[31:14-N] in bits [31:14-N], VA[31-N:20] in bits [13-N:2], and zero in bits [1:0].
- R3: With the high base, the read address is ttb1[31:14] in bits [31:14], VA[31:20] in bits [13:2], and zero in bits [1:0].
- R4: When the disable input of the chosen base is 1 (walk_dis0 for the low base, walk_dis1 for the high base), the walk ends in a fault with code 2 and the captured VA, and no memory request is issued.
- R5: A descriptor with bits [1:0] = 00 ends in a fault with code 1 and fault_va equal to the missing VA.
- R6: A descriptor with bits [1:0] = 01 (second-level pointer) ends in a fault with code 3 and the missing VA.
- R7: A descriptor with bit 1 set and bit 18 clear is a section. The fill carries fill_vpn = VA[31:20] and fill_ppn = desc[31:20]. fill_attr is laid out as: [0] B = desc[2], [1] C = desc[3], [2] XN = desc[4], [6:3] domain = desc[8:5], [9:7] TEX = desc[14:12], [12:10] AP = {desc[15], desc[11:10]}, [13] S = desc[16], [14] nG = desc[17], [15] NS = desc[19], [16] = 0.
- R8: A descriptor with bit 1 set and bit 18 set is a supersection. The fill has fill_ppn = {desc[31:24], VA[23:20]}, fill_attr[16] = 1, and fill_attr[6:3] = 0. The other attribute fields are as in R7.
- R9: Each enabled walk issues exactly one read. mem_req_valid and mem_req_addr stay unchanged until mem_req_ready is seen.
- R10: Each accepted miss yields exactly one outcome, either fill_valid or fault_valid, high for a single cycle. busy is high from the cycle after acceptance until the outcome. A miss_valid raised while busy is ignored.
- R11: After reset, busy, mem_req_valid, fill_valid and fault_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Miss to resolve, taken when idle |
| miss_va | input | 32 | Virtual address that missed |
| ttb0 | input | 32 | Low table base register |
| ttb1 | input | 32 | High table base register |
| split_n | input | 3 | Split value N |
| walk_dis0 | input | 1 | Disable walks through the low base |
| walk_dis1 | input | 1 | Disable walks through the high base |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| fill_valid | output | 1 | Fill record valid (one cycle) |
| fill_vpn | output | 12 | Virtual 1 MB page number |
| fill_ppn | output | 12 | Physical 1 MB page number |
| fill_attr | output | 17 | Attribute record, layout in R7 |
| fault_valid | output | 1 | Fault report valid (one cycle) |
| fault_code | output | 2 | 1 unmapped, 2 walk disabled, 3 second level |
| fault_va | output | 32 | Faulting virtual address |

## Verification
The bench builds the walker with its default parameters: a 32-bit address, a 3-bit split field and 1 MB pages. These values put every split value from 0 to 7 within reach, including the 128-byte low table at N = 7 and the addresses just on either side of each table boundary. Random addresses, bases, descriptors and memory stalls exercise both tables under every N. Directed cases cover the disabled tables, each descriptor type, and a miss raised during a walk.

// File: rtl/l1w_pkg.sv
// Package: shared types and codes for the first-level section walker.
// Assumes a 32-bit descriptor with the type in bits [1:0].
package l1w_pkg;

    // Walk sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_READ_REQ,
        ST_WAIT_RSP,
        ST_DECODE,
        ST_FILL,
        ST_FAULT
    } l1w_state_t;

    // Fault status codes.
    localparam logic [1:0] FLT_NONE    = 2'd0;
    localparam logic [1:0] FLT_INVALID = 2'd1;
    localparam logic [1:0] FLT_OFF     = 2'd2;
    localparam logic [1:0] FLT_LEVEL2  = 2'd3;

    // Descriptor field positions that the decoder depends on.
    localparam int DESC_SUPER_BIT = 18;
    localparam int SUPER_SPAN     = 4;   // 16 MB over 1 MB pages

    // Attribute record handed to the translation cache.
    typedef struct packed {
        logic       super_map;
        logic       ns;
        logic       ng;
        logic       shr;
        logic [2:0] ap;
        logic [2:0] tex;
        logic [3:0] domain;
        logic       xn;
        logic       c;
        logic       b;
    } l1w_attr_t;

    localparam int ATTR_W = $bits(l1w_attr_t);

endpackage

// File: rtl/l1w_base_sel.sv
// Base selector: picks the table base from the split value and forms the
// descriptor byte address. Purely combinational.
// Assumes 2**SPLIT_W - 1 leaves at least two index bits above bit 1.
module l1w_base_sel #(
    parameter int ADDR_W     = 32,
    parameter int SPLIT_W    = 3,
    parameter int PAGE_SHIFT = 20
) (
    input  logic [ADDR_W-1:0]  va,
    input  logic [ADDR_W-1:0]  base_lo,
    input  logic [ADDR_W-1:0]  base_hi,
    input  logic [SPLIT_W-1:0] split_n,
    input  logic               dis_lo,
    input  logic               dis_hi,
    output logic [ADDR_W-1:0]  desc_addr,
    output logic               use_hi,
    output logic               walk_off
);
    // Bits below the table base at N = 0 (index plus word offset).
    localparam int TBL_MAX = ADDR_W - PAGE_SHIFT + 2;

    logic [ADDR_W-1:0]  top_bits;
    logic [SPLIT_W-1:0] n_eff;
    logic [ADDR_W-1:0]  base_mask;
    logic [ADDR_W-1:0]  idx_field;
    logic [ADDR_W-1:0]  base_sel;

    // Decide the table, then splice base and VA index together.
    always_comb begin
        if (split_n == '0) begin
            top_bits = '0;
        end else begin
            top_bits = va >> (ADDR_W - int'(split_n));
        end
        use_hi    = (split_n != '0) && (top_bits != '0);
        n_eff     = use_hi ? '0 : split_n;
        base_sel  = use_hi ? base_hi : base_lo;
        base_mask = {ADDR_W{1'b1}} << (TBL_MAX - int'(n_eff));
        idx_field = ((va >> PAGE_SHIFT) << 2) & ~base_mask;
        desc_addr = (base_sel & base_mask) | idx_field;
        walk_off  = use_hi ? dis_hi : dis_lo;
    end

endmodule

// File: rtl/l1w_desc_dec.sv
// Descriptor decoder: classifies a first-level word and builds either a
// fill record or a fault code. Combinational.
// Assumes a 32-bit descriptor and 1 MB page numbers.
module l1w_desc_dec
    import l1w_pkg::*;
#(
    parameter int DESC_W = 32,
    parameter int VPN_W  = 12
) (
    input  logic [DESC_W-1:0]     desc,
    input  logic [SUPER_SPAN-1:0] va_sub,
    output logic                  is_fill,
    output logic [1:0]            code,
    output logic [VPN_W-1:0]      ppn,
    output l1w_attr_t             attr
);
    logic is_super;
    logic unused_desc;

    assign is_super    = desc[DESC_SUPER_BIT];
    assign unused_desc = desc[9];

    // Map the descriptor type and fields onto the fill or fault result.
    always_comb begin
        is_fill = 1'b0;
        code    = FLT_NONE;
        ppn     = '0;
        attr    = '0;
        if (desc[1]) begin
            is_fill        = 1'b1;
            attr.super_map = is_super;
            attr.ns        = desc[19];
            attr.ng        = desc[17];
            attr.shr       = desc[16];
            attr.ap        = {desc[15], desc[11:10]};
            attr.tex       = desc[14:12];
            attr.domain    = is_super ? 4'd0 : desc[8:5];
            attr.xn        = desc[4];
            attr.c         = desc[3];
            attr.b         = desc[2];
            if (is_super) begin
                ppn = {desc[DESC_W-1 -: VPN_W-SUPER_SPAN], va_sub};
            end else begin
                ppn = desc[DESC_W-1 -: VPN_W];
            end
        end else if (desc[0]) begin
            code = FLT_LEVEL2;
        end else begin
            code = FLT_INVALID;
        end
    end

endmodule

// File: rtl/l1w_walk_ctrl.sv
// Walk controller: captures a miss, steps through base selection, the
// single descriptor read, the decode, and one outcome cycle.
// Assumes the memory replies once per accepted request.
module l1w_walk_ctrl
    import l1w_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SPLIT_W = 3,
    parameter int DESC_W  = 32,
    parameter int VPN_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               miss_valid,
    input  logic [ADDR_W-1:0]  miss_va,
    input  logic [ADDR_W-1:0]  ttb0_in,
    input  logic [ADDR_W-1:0]  ttb1_in,
    input  logic [SPLIT_W-1:0] split_in,
    input  logic               dis0_in,
    input  logic               dis1_in,
    output logic [ADDR_W-1:0]  cap_va,
    output logic [ADDR_W-1:0]  cap_ttb0,
    output logic [ADDR_W-1:0]  cap_ttb1,
    output logic [SPLIT_W-1:0] cap_split,
    output logic               cap_dis0,
    output logic               cap_dis1,
    input  logic [ADDR_W-1:0]  sel_addr,
    input  logic               sel_off,
    output logic               mem_req_valid,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_req_ready,
    input  logic               mem_rsp_valid,
    input  logic [DESC_W-1:0]  mem_rsp_data,
    output logic [DESC_W-1:0]  desc_q,
    input  logic               dec_fill,
    input  logic [1:0]         dec_code,
    input  logic [VPN_W-1:0]   dec_ppn,
    input  l1w_attr_t          dec_attr,
    output logic               busy,
    output logic               fill_valid,
    output logic [VPN_W-1:0]   fill_ppn,
    output l1w_attr_t          fill_attr,
    output logic               fault_valid,
    output logic [1:0]         fault_code
);
    l1w_state_t        state_q;
    l1w_state_t        state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        code_q;
    logic [VPN_W-1:0]  ppn_q;
    l1w_attr_t         attr_q;

    // Next-state selection for the walk sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:     if (miss_valid) state_d = ST_SELECT;
            ST_SELECT:   state_d = sel_off ? ST_FAULT : ST_READ_REQ;
            ST_READ_REQ: if (mem_req_ready) state_d = ST_WAIT_RSP;
            ST_WAIT_RSP: if (mem_rsp_valid) state_d = ST_DECODE;
            ST_DECODE:   state_d = dec_fill ? ST_FILL : ST_FAULT;
            ST_FILL:     state_d = ST_IDLE;
            ST_FAULT:    state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Capture the miss context when a walk starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_va    <= '0;
            cap_ttb0  <= '0;
            cap_ttb1  <= '0;
            cap_split <= '0;
            cap_dis0  <= 1'b0;
            cap_dis1  <= 1'b0;
        end else if (state_q == ST_IDLE && miss_valid) begin
            cap_va    <= miss_va;
            cap_ttb0  <= ttb0_in;
            cap_ttb1  <= ttb1_in;
            cap_split <= split_in;
            cap_dis0  <= dis0_in;
            cap_dis1  <= dis1_in;
        end
    end

    // Hold the request address and the returned descriptor word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            desc_q <= '0;
        end else begin
            if (state_q == ST_SELECT) addr_q <= sel_addr;
            if (state_q == ST_WAIT_RSP && mem_rsp_valid) desc_q <= mem_rsp_data;
        end
    end

    // Register the outcome record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= FLT_NONE;
            ppn_q  <= '0;
            attr_q <= '0;
        end else if (state_q == ST_SELECT && sel_off) begin
            code_q <= FLT_OFF;
        end else if (state_q == ST_DECODE) begin
            code_q <= dec_code;
            ppn_q  <= dec_ppn;
            attr_q <= dec_attr;
        end
    end

    assign busy          = (state_q != ST_IDLE);
    assign mem_req_valid = (state_q == ST_READ_REQ);
    assign mem_req_addr  = addr_q;
    assign fill_valid    = (state_q == ST_FILL);
    assign fill_ppn      = ppn_q;
    assign fill_attr     = attr_q;
    assign fault_valid   = (state_q == ST_FAULT);
    assign fault_code    = code_q;

endmodule

// File: rtl/l1_section_walker.sv
// Top: first-level section walker. Joins the controller, base selector and
// descriptor decoder. Assumes one outstanding walk at a time.
module l1_section_walker
    import l1w_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SPLIT_W    = 3,
    parameter int PAGE_SHIFT = 20,
    parameter int DESC_W     = 32,
    parameter int VPN_W      = ADDR_W - PAGE_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               miss_valid,
    input  logic [ADDR_W-1:0]  miss_va,
    input  logic [ADDR_W-1:0]  ttb0,
    input  logic [ADDR_W-1:0]  ttb1,
    input  logic [SPLIT_W-1:0] split_n,
    input  logic               walk_dis0,
    input  logic               walk_dis1,
    output logic               busy,
    output logic               mem_req_valid,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_req_ready,
    input  logic               mem_rsp_valid,
    input  logic [DESC_W-1:0]  mem_rsp_data,
    output logic               fill_valid,
    output logic [VPN_W-1:0]   fill_vpn,
    output logic [VPN_W-1:0]   fill_ppn,
    output logic [ATTR_W-1:0]  fill_attr,
    output logic               fault_valid,
    output logic [1:0]         fault_code,
    output logic [ADDR_W-1:0]  fault_va
);
    logic [ADDR_W-1:0]  cap_va;
    logic [ADDR_W-1:0]  cap_ttb0;
    logic [ADDR_W-1:0]  cap_ttb1;
    logic [SPLIT_W-1:0] cap_split;
    logic               cap_dis0;
    logic               cap_dis1;
    logic [ADDR_W-1:0]  sel_addr;
    logic               sel_off;
    logic               unused_use_hi;
    logic [DESC_W-1:0]  desc_q;
    logic               dec_fill;
    logic [1:0]         dec_code;
    logic [VPN_W-1:0]   dec_ppn;
    l1w_attr_t          dec_attr;
    l1w_attr_t          rec_attr;

    l1w_walk_ctrl #(
        .ADDR_W (ADDR_W),
        .SPLIT_W(SPLIT_W),
        .DESC_W (DESC_W),
        .VPN_W  (VPN_W)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .miss_valid   (miss_valid),
        .miss_va      (miss_va),
        .ttb0_in      (ttb0),
        .ttb1_in      (ttb1),
        .split_in     (split_n),
        .dis0_in      (walk_dis0),
        .dis1_in      (walk_dis1),
        .cap_va       (cap_va),
        .cap_ttb0     (cap_ttb0),
        .cap_ttb1     (cap_ttb1),
        .cap_split    (cap_split),
        .cap_dis0     (cap_dis0),
        .cap_dis1     (cap_dis1),
        .sel_addr     (sel_addr),
        .sel_off      (sel_off),
        .mem_req_valid(mem_req_valid),
        .mem_req_addr (mem_req_addr),
        .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .desc_q       (desc_q),
        .dec_fill     (dec_fill),
        .dec_code     (dec_code),
        .dec_ppn      (dec_ppn),
        .dec_attr     (dec_attr),
        .busy         (busy),
        .fill_valid   (fill_valid),
        .fill_ppn     (fill_ppn),
        .fill_attr    (rec_attr),
        .fault_valid  (fault_valid),
        .fault_code   (fault_code)
    );

    l1w_base_sel #(
        .ADDR_W    (ADDR_W),
        .SPLIT_W   (SPLIT_W),
        .PAGE_SHIFT(PAGE_SHIFT)
    ) sel_i (
        .va       (cap_va),
        .base_lo  (cap_ttb0),
        .base_hi  (cap_ttb1),
        .split_n  (cap_split),
        .dis_lo   (cap_dis0),
        .dis_hi   (cap_dis1),
        .desc_addr(sel_addr),
        .use_hi   (unused_use_hi),
        .walk_off (sel_off)
    );

    l1w_desc_dec #(
        .DESC_W(DESC_W),
        .VPN_W (VPN_W)
    ) dec_i (
        .desc   (desc_q),
        .va_sub (cap_va[PAGE_SHIFT +: SUPER_SPAN]),
        .is_fill(dec_fill),
        .code   (dec_code),
        .ppn    (dec_ppn),
        .attr   (dec_attr)
    );

    assign fill_vpn  = cap_va[ADDR_W-1 -: VPN_W];
    assign fill_attr = rec_attr;
    assign fault_va  = cap_va;

endmodule

// File: rtl/l1w_walk_chk.sv
// Checker: protocol and outcome properties of the section walker, bound
// to the top module. Tracks the accepted VA and whether a read was taken.
module l1w_walk_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        miss_valid,
    input logic [31:0] miss_va,
    input logic        busy,
    input logic        mem_req_valid,
    input logic [31:0] mem_req_addr,
    input logic        mem_req_ready,
    input logic        fill_valid,
    input logic [11:0] fill_vpn,
    input logic [11:0] fill_ppn,
    input logic [16:0] fill_attr,
    input logic        fault_valid,
    input logic [1:0]  fault_code,
    input logic [31:0] fault_va
);
    logic [31:0] va_seen;
    logic        read_taken;

    // Follow the walk from acceptance to the read handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_seen    <= '0;
            read_taken <= 1'b0;
        end else if (miss_valid && !busy) begin
            va_seen    <= miss_va;
            read_taken <= 1'b0;
        end else if (mem_req_valid && mem_req_ready) begin
            read_taken <= 1'b1;
        end
    end

    p_single_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_valid && fault_valid));

    p_outcome_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid || fault_valid) |=> !(fill_valid || fault_valid));

    p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && !busy) |=> busy);

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_one_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |-> !read_taken);

    p_no_read_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && fault_code == 2'd2) |-> !read_taken);

    p_fill_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (read_taken && fill_vpn == va_seen[31:20]));

    p_fault_va_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (fault_va == va_seen));

    p_super_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_attr[16]) |-> (fill_ppn[3:0] == va_seen[23:20]));

endmodule

bind l1_section_walker l1w_walk_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .miss_valid   (miss_valid),
    .miss_va      (miss_va),
    .busy         (busy),
    .mem_req_valid(mem_req_valid),
    .mem_req_addr (mem_req_addr),
    .mem_req_ready(mem_req_ready),
    .fill_valid   (fill_valid),
    .fill_vpn     (fill_vpn),
    .fill_ppn     (fill_ppn),
    .fill_attr    (fill_attr),
    .fault_valid  (fault_valid),
    .fault_code   (fault_code),
    .fault_va     (fault_va)
);

// File: tb/l1_section_walker_tb_top.sv
// Bench: directed and seeded random walks against a behavioural memory,
// with expected results computed from the requirements.
module l1_section_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        miss_valid;
    logic [31:0] miss_va;
    logic [31:0] ttb0;
    logic [31:0] ttb1;
    logic [2:0]  split_n;
    logic        walk_dis0;
    logic        walk_dis1;
    logic        busy;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_req_ready;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        fill_valid;
    logic [11:0] fill_vpn;
    logic [11:0] fill_ppn;
    logic [16:0] fill_attr;
    logic        fault_valid;
    logic [1:0]  fault_code;
    logic [31:0] fault_va;

    int n_tests = 0;
    int n_fail  = 0;
    bit summary_done = 1'b0;

    always #2 clk = ~clk;

    l1_section_walker dut_i (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_va(miss_va),
        .ttb0(ttb0), .ttb1(ttb1), .split_n(split_n), .walk_dis0(walk_dis0),
        .walk_dis1(walk_dis1), .busy(busy), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_attr(fill_attr), .fault_valid(fault_valid),
        .fault_code(fault_code), .fault_va(fault_va)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                       input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
        end
    endtask

    function automatic logic exp_hi(input logic [31:0] va, input logic [2:0] n);
        logic h = 1'b0;
        for (int i = 0; i < 32; i++) begin
            if (n != 0 && i >= 32 - int'(n) && va[i]) h = 1'b1;
        end
        return h;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] va, t0, t1,
                                             input logic [2:0] n);
        logic [31:0] a;
        logic        h  = exp_hi(va, n);
        int          lo = h ? 14 : 14 - int'(n);
        for (int i = 0; i < 32; i++) begin
            if (i < 2)        a[i] = 1'b0;
            else if (i >= lo) a[i] = h ? t1[i] : t0[i];
            else              a[i] = va[i + 18];
        end
        return a;
    endfunction

    function automatic logic [16:0] exp_attr(input logic [31:0] d);
        return {d[18], d[19], d[17], d[16], d[15], d[11:10], d[14:12],
                (d[18] ? 4'd0 : d[8:5]), d[4], d[3], d[2]};
    endfunction

    function automatic logic [31:0] make_desc(input int kind, input logic [31:0] r);
        logic [31:0] d = r;
        case (kind)
            0: d[1:0] = 2'b00;
            1: d[1:0] = 2'b01;
            2: begin d[1] = 1'b1; d[18] = 1'b0; end
            default: begin d[1] = 1'b1; d[18] = 1'b1; end
        endcase
        return d;
    endfunction

    task automatic run_walk(input logic [31:0] va, t0, t1, input logic [2:0] n,
                            input logic d0, d1, input logic [31:0] desc,
                            input bit inject);
        logic        h     = exp_hi(va, n);
        logic        off   = h ? d1 : d0;
        logic [31:0] eaddr = exp_addr(va, t0, t1, n);
        int          reqs  = 0;
        int          dly   = 0;
        int          extra = 0;
        bit          pend  = 0;
        bit          sent  = 0;
        bit          done  = 0;
        bit          gfill = 0;
        bit          gfault = 0;
        logic [31:0] gaddr = '0;
        logic [1:0]  gcode = '0;
        logic [31:0] gva   = '0;
        logic [11:0] gvpn  = '0;
        logic [11:0] gppn  = '0;
        logic [16:0] gattr = '0;
        @(negedge clk);
        miss_va = va; ttb0 = t0; ttb1 = t1; split_n = n;
        walk_dis0 = d0; walk_dis1 = d1; miss_valid = 1'b1;
        for (int it = 0; it < 300 && !done; it++) begin
            @(negedge clk);
            miss_valid    = (it == 0) && inject;
            if (inject && it == 0) miss_va = va ^ 32'hFFF0_0000;
            mem_rsp_valid = 1'b0;
            mem_req_ready = 1'b0;
            if (fill_valid || fault_valid) begin
                gfill = fill_valid; gfault = fault_valid; gcode = fault_code;
                gva = fault_va; gvpn = fill_vpn; gppn = fill_ppn; gattr = fill_attr;
                done = 1'b1;
            end else if (mem_req_valid && !pend) begin
                if ($urandom % 3 != 0) begin
                    mem_req_ready = 1'b1; pend = 1'b1; reqs++;
                    gaddr = mem_req_addr; dly = int'($urandom % 4);
                end
            end else if (pend && !sent) begin
                if (dly == 0) begin
                    mem_rsp_valid = 1'b1; mem_rsp_data = desc; sent = 1'b1;
                end else begin
                    dly--;
                end
            end
        end
        chk(done, "R10 outcome seen", 64'(done), 64'd1);
        chk(gfill != gfault, "R10 exactly one outcome", {gfill, gfault}, 64'd1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (busy || mem_req_valid || fill_valid || fault_valid) extra++;
        end
        chk(extra == 0, "R10 idle after outcome, stray miss ignored", 64'(extra), 0);
        if (off) begin
            chk(reqs == 0, "R4 no read when disabled", 64'(reqs), 0);
            chk(gfault && gcode == 2'd2, "R4 disabled code", {gfault, gcode}, 64'h6);
            chk(gva == va, "R4 fault va", gva, va);
        end else begin
            chk(reqs == 1, "R9 single read", 64'(reqs), 1);
            chk(gaddr == eaddr, h ? "R1 R3 address" : "R1 R2 address", gaddr, eaddr);
            if (desc[1:0] == 2'b00) begin
                chk(gfault && gcode == 2'd1, "R5 invalid code", {gfault, gcode}, 64'h5);
                chk(gva == va, "R5 fault va", gva, va);
            end else if (desc[1:0] == 2'b01) begin
                chk(gfault && gcode == 2'd3, "R6 level2 code", {gfault, gcode}, 64'h7);
                chk(gva == va, "R6 fault va", gva, va);
            end else if (!desc[18]) begin
                chk(gfill && gvpn == va[31:20], "R7 vpn", gvpn, va[31:20]);
                chk(gppn == desc[31:20], "R7 ppn", gppn, desc[31:20]);
                chk(gattr == exp_attr(desc), "R7 attr", gattr, exp_attr(desc));
            end else begin
                chk(gfill && gvpn == va[31:20], "R8 vpn", gvpn, va[31:20]);
                chk(gppn == {desc[31:24], va[23:20]}, "R8 ppn", gppn,
                    {desc[31:24], va[23:20]});
                chk(gattr == exp_attr(desc), "R8 attr", gattr, exp_attr(desc));
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; miss_valid = 1'b0; miss_va = '0; ttb0 = '0; ttb1 = '0;
        split_n = '0; walk_dis0 = 1'b0; walk_dis1 = 1'b0; mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req_valid && !fill_valid && !fault_valid, "R11 reset state",
            {busy, mem_req_valid, fill_valid, fault_valid}, 0);

        // Directed corners.
        run_walk(32'hFFF1_2345, 32'hA5A5_4000, 32'h1234_C000, 3'd0, 0, 0,
                 make_desc(2, 32'h3F2A_5DEC), 0);               // R1 N=0 high VA low base
        run_walk(32'h01F0_0000, 32'h8765_4321, 32'h5555_5555, 3'd7, 0, 0,
                 make_desc(3, 32'hC0DE_F00D), 0);               // R2 N=7 last low entry
        run_walk(32'h0200_0000, 32'h8765_4321, 32'h5555_5555, 3'd7, 0, 0,
                 make_desc(2, 32'h0010_0C0E), 0);               // R3 N=7 first high VA
        run_walk(32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_4000, 3'd1, 0, 0,
                 make_desc(3, 32'hFFFF_FFFF), 0);               // R3 N=1 high half
        run_walk(32'h7FF0_0000, 32'hFFFF_FFFF, 32'h0000_4000, 3'd1, 0, 0,
                 make_desc(2, 32'hFFFF_FFFF), 0);               // R2 N=1 top of low half
        run_walk(32'h0010_0000, 32'h0, 32'h0, 3'd3, 1, 0,
                 make_desc(2, 32'h1), 0);                       // R4 low base disabled
        run_walk(32'hF000_0000, 32'h0, 32'h0, 3'd3, 1, 0,
                 make_desc(2, 32'h0), 0);                       // R4 low off, high used
        run_walk(32'hF000_0000, 32'h0, 32'h0, 3'd3, 0, 1,
                 make_desc(2, 32'h0), 0);                       // R4 high base disabled
        run_walk(32'h0040_0000, 32'h0001_0000, 32'h0, 3'd0, 0, 0,
                 make_desc(0, 32'hFFFF_FFFC), 0);               // R5 invalid
        run_walk(32'h0050_0000, 32'h0001_0000, 32'h0, 3'd2, 0, 0,
                 make_desc(1, 32'h1234_5401), 0);               // R6 second level
        run_walk(32'h3F20_000C, 32'h0000_8000, 32'h0, 3'd0, 0, 0,
                 make_desc(2, 32'h3F2F_FFFE), 1);               // R10 miss while busy
        run_walk(32'h00A0_0000, 32'h0000_8000, 32'h0, 3'd0, 0, 0,
                 make_desc(3, 32'h4000_0000), 1);               // R8 with stray miss

        // Seeded random walks.
        for (int t = 0; t < 120; t++) begin
            logic [31:0] va = $urandom;
            logic [2:0]  n  = 3'($urandom % 8);
            if ($urandom % 2 == 0) va = va >> ($urandom % 9);
            run_walk(va, $urandom, $urandom, n, ($urandom % 8) == 0,
                     ($urandom % 8) == 0, make_desc(int'($urandom % 4), $urandom),
                     ($urandom % 4) == 0);
        end

        if (!summary_done) begin
            summary_done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
        $finish;
    end

endmodule